// File: doc/BRIEF.md
# Double-Buffered Crosspoint Routing Configuration

This block keeps the routing setup of a crosspoint switch with 33 inputs and 17 outputs. Each output has two registers. The first is a pending register that the host loads one output at a time. The second is an active register that drives the switch. A host reaches the block over a shared 7-bit bidirectional data bus and a 5-bit output address. The strobes are all active low: chip select, write, read and a commit strobe. The commit strobe moves every pending word into the active rank on one clock edge, so a whole new routing pattern takes effect at once.

Each active word has two fields. Bits 5:0 are the input select and bit 6 is the output enable. A select code of 33 or higher is a legal code that routes nothing. The host can read an active word back over the same bus. A separate active-low disable input clears every active enable bit at once, without waiting for a clock and without regard to chip select. It leaves the select fields and the whole pending rank alone. That input also serves as the block reset. It is released through a two-stage synchronizer, so it takes hold at once but lets go only on clock edges.

Top module: `xpt_cfg`

## Requirements
- R1: On a clock edge where `cs_n` and `we_n` are both low and `addr_i` is below 17, the bus value is stored in the pending register of the addressed output only. The value is a 7-bit word: bits 5:0 are the select and bit 6 is the enable.
- R2: Writes to addresses 17 to 31 change no register. A readback of such an address returns 0.
- R3: No pending register changes on an edge where `cs_n` is high or `we_n` is high.
- R4: On a clock edge where `cs_n` and `upd_n` are both low, all 17 pending words are copied at once into the active rank. `sel_o[6i+5:6i]` takes bits 5:0 of word i and `en_o[i]` takes bit 6. The new values show after that edge.
- R5: With `cs_n` high or `upd_n` high, the active rank does not change, and `sel_o` and `en_o` hold their values.
- R6: While `cs_n` and `re_n` are both low, the block drives `data_io` with the active word of the addressed output: `{en, sel}`. Otherwise it leaves the bus undriven.
- R7: While `dis_n` is low, every bit of `en_o` is 0 with no clock edge needed, whatever the state of `cs_n`. `sel_o` and the pending rank stay unchanged.
- R8: After `dis_n` rises, `en_o` stays 0 through the second following clock edge, even if a commit is held. The first commit to take effect is the one on the third edge.
- R9: `live_o[i]` is 1 exactly when `en_o[i]` is 1 and the select of output i is below 33.
- R10: A write and a readback on the same edge, with the bus not driven from outside, copies the active word of that output into its pending register.
- R11: When a write and a commit land on the same edge, the commit takes the pending contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| dis_n | input | 1 | Active-low global output disable and reset |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe |
| re_n | input | 1 | Active-low readback strobe |
| upd_n | input | 1 | Active-low commit strobe |
| addr_i | input | 5 | Output address |
| data_io | inout | 7 | Shared data bus, {enable, select} |
| sel_o | output | 102 | Active input select, 6 bits per output |
| en_o | output | 17 | Active output enables |
| live_o | output | 17 | Output enabled with a select that names a real input |

## Verification
The assertions assume the host never drives `data_io` while a readback has the bus, so any value seen during a write is either the host's own word or the active word. They also assume the strobes change only away from the rising clock edge. The bench moves every input on the falling edge and turns its bus driver off for every readback, including the combined write-and-read cycle. The pending rank starts undefined, so the assertions on committed values are used only after the bench has written all 17 pending registers, and the disable input is held low at start so the enable bits begin cleared.

// File: rtl/xpt_cfg_pkg.sv
package xpt_cfg_pkg;
  localparam int XPT_OUTS = 17;
  localparam int XPT_INS  = 33;

  function automatic int sel_width(input int n_in);
    return (n_in > 1) ? $clog2(n_in) : 1;
  endfunction
endpackage

// File: rtl/xpt_rst_sync.sv
module xpt_rst_sync (
  input  logic clk,
  input  logic dis_n_i,
  output logic dis_sync_n_o
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge dis_n_i) begin
    if (!dis_n_i) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign dis_sync_n_o = stage_q[1];
endmodule

// File: rtl/xpt_hold_bank.sv
module xpt_hold_bank #(
  parameter int N_OUT  = 17,
  parameter int WORD_W = 7,
  parameter int ADDR_W = 5
) (
  input  logic                    clk,
  input  logic                    wr_go_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [WORD_W-1:0]       data_i,
  output logic [N_OUT*WORD_W-1:0] word_o
);
  genvar gi;
  generate
    for (gi = 0; gi < N_OUT; gi++) begin : g_slot
      logic              load;
      logic [WORD_W-1:0] word_q;
      logic [WORD_W-1:0] word_d;

      always_comb begin
        load   = wr_go_i && (addr_i == ADDR_W'(gi));
        word_d = load ? data_i : word_q;
      end

      always_ff @(posedge clk) begin
        if (load) begin
          word_q <= word_d;
        end
      end

      assign word_o[gi*WORD_W +: WORD_W] = word_q;
    end
  endgenerate
endmodule

// File: rtl/xpt_active_bank.sv
module xpt_active_bank #(
  parameter int N_OUT = 17,
  parameter int SEL_W = 6,
  localparam int WORD_W = SEL_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd_go_i,
  input  logic [N_OUT*WORD_W-1:0] hold_i,
  output logic [N_OUT*SEL_W-1:0]  sel_o,
  output logic [N_OUT-1:0]        en_o
);
  genvar gi;
  generate
    for (gi = 0; gi < N_OUT; gi++) begin : g_slot
      logic [SEL_W-1:0] sel_q;
      logic [SEL_W-1:0] sel_d;
      logic             en_q;
      logic             en_d;

      always_comb begin
        sel_d = upd_go_i ? hold_i[gi*WORD_W +: SEL_W] : sel_q;
        en_d  = upd_go_i ? hold_i[gi*WORD_W + SEL_W]  : en_q;
      end

      always_ff @(posedge clk) begin
        if (upd_go_i) begin
          sel_q <= sel_d;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en_q <= 1'b0;
        end else if (upd_go_i) begin
          en_q <= en_d;
        end
      end

      assign sel_o[gi*SEL_W +: SEL_W] = sel_q;
      assign en_o[gi]                 = en_q;

      // R8: no enable may survive the reset release edge
      a_r8_release_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !en_q);
    end
  endgenerate
endmodule

// File: rtl/xpt_readback.sv
module xpt_readback #(
  parameter int N_OUT  = 17,
  parameter int N_IN   = 33,
  parameter int SEL_W  = 6,
  parameter int ADDR_W = 5,
  localparam int WORD_W = SEL_W + 1
) (
  input  logic                   cs_n,
  input  logic                   re_n,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [N_OUT*SEL_W-1:0] sel_i,
  input  logic [N_OUT-1:0]       en_i,
  output logic                   drive_o,
  output logic [WORD_W-1:0]      word_o,
  output logic [N_OUT-1:0]       live_o
);
  always_comb begin
    drive_o = !cs_n && !re_n;
    word_o  = '0;
    for (int i = 0; i < N_OUT; i++) begin
      if (addr_i == ADDR_W'(i)) begin
        word_o = {en_i[i], sel_i[i*SEL_W +: SEL_W]};
      end
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_OUT; gi++) begin : g_live
      assign live_o[gi] = en_i[gi] && (sel_i[gi*SEL_W +: SEL_W] < SEL_W'(N_IN));
    end
  endgenerate
endmodule

// File: rtl/xpt_cfg.sv
module xpt_cfg
  import xpt_cfg_pkg::*;
#(
  parameter int N_OUT = XPT_OUTS,
  parameter int N_IN  = XPT_INS,
  localparam int SEL_W  = sel_width(N_IN),
  localparam int WORD_W = SEL_W + 1,
  localparam int ADDR_W = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic                   clk,
  input  logic                   dis_n,
  input  logic                   cs_n,
  input  logic                   we_n,
  input  logic                   re_n,
  input  logic                   upd_n,
  input  logic [ADDR_W-1:0]      addr_i,
  inout  wire  [WORD_W-1:0]      data_io,
  output logic [N_OUT*SEL_W-1:0] sel_o,
  output logic [N_OUT-1:0]       en_o,
  output logic [N_OUT-1:0]       live_o
);
  logic                    dis_sync_n;
  logic                    wr_go;
  logic                    upd_go;
  logic                    rd_drive;
  logic [WORD_W-1:0]       rd_word;
  logic [N_OUT*WORD_W-1:0] hold_w;

  assign wr_go  = !cs_n && !we_n;
  assign upd_go = !cs_n && !upd_n;

  xpt_rst_sync u_sync (
    .clk          (clk),
    .dis_n_i      (dis_n),
    .dis_sync_n_o (dis_sync_n)
  );

  xpt_hold_bank #(.N_OUT(N_OUT), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_hold (
    .clk     (clk),
    .wr_go_i (wr_go),
    .addr_i  (addr_i),
    .data_i  (data_io),
    .word_o  (hold_w)
  );

  xpt_active_bank #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_act (
    .clk      (clk),
    .rst_n    (dis_sync_n),
    .upd_go_i (upd_go),
    .hold_i   (hold_w),
    .sel_o    (sel_o),
    .en_o     (en_o)
  );

  xpt_readback #(.N_OUT(N_OUT), .N_IN(N_IN), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_rd (
    .cs_n    (cs_n),
    .re_n    (re_n),
    .addr_i  (addr_i),
    .sel_i   (sel_o),
    .en_i    (en_o),
    .drive_o (rd_drive),
    .word_o  (rd_word),
    .live_o  (live_o)
  );

  assign data_io = rd_drive ? rd_word : {WORD_W{1'bz}};

  // R2: an out-of-range readback shows zero on the bus
  a_r2_oob_read: assert property (@(posedge clk) disable iff (!dis_sync_n)
    (rd_drive && (addr_i >= ADDR_W'(N_OUT))) |-> (data_io == '0));

  // R9: a live output always has its enable set
  a_r9_live_subset: assert property (@(posedge clk) disable iff (!dis_sync_n)
    $countones(live_o & ~en_o) == 0);

  genvar gi;
  generate
    for (gi = 0; gi < N_OUT; gi++) begin : g_chk
      // R1: a write lands in the addressed pending slot
      a_r1_write_lands: assert property (@(posedge clk) disable iff (!dis_sync_n)
        (wr_go && (addr_i == ADDR_W'(gi))) |=>
          (hold_w[gi*WORD_W +: WORD_W] == $past(data_io)));

      // R3: an unaddressed or unstrobed slot keeps its word
      a_r3_hold_keeps: assert property (@(posedge clk) disable iff (!dis_sync_n)
        !(wr_go && (addr_i == ADDR_W'(gi))) |=> $stable(hold_w[gi*WORD_W +: WORD_W]));

      // R4: a commit copies the pending word into the active slot
      a_r4_commit_copy: assert property (@(posedge clk) disable iff (!dis_sync_n)
        upd_go |=> ((sel_o[gi*SEL_W +: SEL_W] == $past(hold_w[gi*WORD_W +: SEL_W])) &&
                    (en_o[gi] == $past(hold_w[gi*WORD_W + SEL_W]))));

      // R5: without a commit the active slot holds
      a_r5_active_holds: assert property (@(posedge clk) disable iff (!dis_sync_n)
        !upd_go |=> ($stable(sel_o[gi*SEL_W +: SEL_W]) && $stable(en_o[gi])));
    end
  endgenerate
endmodule

// File: tb/xpt_cfg_test.sv
`timescale 1ns/1ps
module xpt_cfg_test;
  localparam int NO = 17;
  localparam int NI = 33;
  localparam int SW = 6;
  localparam int WW = 7;

  logic            clk = 1'b0;
  logic            dis_n, cs_n, we_n, re_n, upd_n;
  logic [4:0]      addr;
  logic            tb_oe;
  logic [WW-1:0]   tb_dat;
  wire  [WW-1:0]   bus;
  logic [NO*SW-1:0] sel_o;
  logic [NO-1:0]   en_o, live_o;

  int errors = 0;
  int checks = 0;

  logic [WW-1:0] m_hold [NO];
  logic [SW-1:0] m_sel  [NO];
  logic          m_en   [NO];

  assign bus = tb_oe ? tb_dat : {WW{1'bz}};

  always #2 clk = ~clk;

  xpt_cfg uut (
    .clk(clk), .dis_n(dis_n), .cs_n(cs_n), .we_n(we_n), .re_n(re_n),
    .upd_n(upd_n), .addr_i(addr), .data_io(bus),
    .sel_o(sel_o), .en_o(en_o), .live_o(live_o)
  );

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    cs_n = 1; we_n = 1; re_n = 1; upd_n = 1; tb_oe = 0; tb_dat = '0; addr = '0;
  endtask

  // one clocked host cycle; called and returns at a falling edge
  task automatic cyc(input bit c, input bit w, input bit r, input bit u,
                     input int a, input bit drv, input logic [WW-1:0] d);
    logic [WW-1:0] busv;
    cs_n = !c; we_n = !w; re_n = !r; upd_n = !u;
    addr = 5'(a); tb_oe = drv; tb_dat = d;
    #1;
    busv = bus;
    @(posedge clk);
    if (c && u) begin
      for (int i = 0; i < NO; i++) begin
        m_sel[i] = m_hold[i][SW-1:0];
        m_en[i]  = m_hold[i][SW];
      end
    end
    if (c && w && a < NO) m_hold[a] = busv;
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input int a, input logic [WW-1:0] d);
    cyc(1, 1, 0, 0, a, 1, d);
  endtask

  task automatic commit();
    cyc(1, 0, 0, 1, 0, 0, '0);
  endtask

  task automatic rd(input int a, output logic [WW-1:0] v);
    cs_n = 0; re_n = 0; addr = 5'(a); tb_oe = 0;
    #1;
    v = bus;
    @(negedge clk);
    idle();
  endtask

  task automatic check_outs(input string tag);
    for (int i = 0; i < NO; i++) begin
      chk(sel_o[i*SW +: SW] == m_sel[i], {tag, " sel"}, sel_o[i*SW +: SW], m_sel[i]);
      chk(en_o[i] == m_en[i], {tag, " en"}, en_o[i], m_en[i]);
      chk(live_o[i] == (m_en[i] && m_sel[i] < NI), "R9 live",
          live_o[i], m_en[i] && m_sel[i] < NI);
    end
  endtask

  function automatic logic [WW-1:0] pat(input int i, input int k);
    pat = {1'((i + k) % 3 != 0), 6'((i * 7 + k * 11 + 2) % 64)};
  endfunction

  initial begin
    logic [WW-1:0] v;
    logic [NO*SW-1:0] sel_snap;
    idle();
    dis_n = 0;
    repeat (3) @(negedge clk);
    // R7 reset state: enables clear
    chk(en_o == '0, "R7 reset en", en_o, 0);
    dis_n = 1;
    repeat (3) @(negedge clk);
    chk(en_o == '0, "R8 after release", en_o, 0);

    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < NO; i++) wr(i, pat(i, k));
      commit();
      check_outs("R1 R4 sweep");
      for (int i = 0; i < NO; i++) begin
        rd(i, v);
        chk(v == {m_en[i], m_sel[i]}, "R6 readback", v, {m_en[i], m_sel[i]});
      end
    end

    // R2 out-of-range addresses
    for (int a = NO; a < 32; a++) wr(a, 7'h7f);
    for (int a = NO; a < 32; a++) begin
      rd(a, v);
      chk(v == '0, "R2 oob read", v, 0);
    end
    commit();
    check_outs("R2 oob write");

    // R3 writes without strobe
    for (int i = 0; i < NO; i++) begin
      cyc(0, 1, 0, 0, i, 1, 7'h55);
      cyc(1, 0, 0, 0, i, 1, 7'h2a);
    end
    commit();
    check_outs("R3 no write");

    // R5 commit gated
    for (int i = 0; i < NO; i++) wr(i, pat(i, 5));
    cyc(0, 0, 0, 1, 0, 0, '0);
    check_outs("R5 gated commit");
    cyc(1, 0, 0, 0, 0, 0, '0);
    check_outs("R5 no commit");
    commit();
    check_outs("R4 commit");

    // R6 bus released when not selected
    cs_n = 1; re_n = 0; tb_oe = 1; tb_dat = 7'h55; addr = 5'd3;
    #1;
    chk(bus == 7'h55, "R6 cs high float", bus, 7'h55);
    @(negedge clk); idle();
    re_n = 1; cs_n = 0; tb_oe = 1; tb_dat = 7'h2a; addr = 5'd4;
    #1;
    chk(bus == 7'h2a, "R6 re high float", bus, 7'h2a);
    @(negedge clk); idle();

    // R7 asynchronous disable, cs ignored
    sel_snap = sel_o;
    #0.5 dis_n = 0;
    #0.3;
    chk(en_o == '0, "R7 immediate", en_o, 0);
    chk(sel_o == sel_snap, "R7 sel kept", 0, 0);
    for (int i = 0; i < NO; i++) m_en[i] = 0;
    @(negedge clk);
    dis_n = 1;
    repeat (3) @(negedge clk);
    check_outs("R7 during hold");
    commit();
    check_outs("R7 pending kept");

    // R8 release timing with commit held
    dis_n = 0;
    @(negedge clk);
    for (int i = 0; i < NO; i++) m_en[i] = 0;
    cs_n = 0; upd_n = 0;
    @(negedge clk);
    dis_n = 1;
    @(negedge clk);
    chk(en_o == '0, "R8 edge1", en_o, 0);
    @(negedge clk);
    chk(en_o == '0, "R8 edge2", en_o, 0);
    @(negedge clk);
    idle();
    for (int i = 0; i < NO; i++) begin
      m_sel[i] = m_hold[i][SW-1:0];
      m_en[i]  = m_hold[i][SW];
    end
    check_outs("R8 edge3");

    // R10 combined write and readback
    wr(6, 7'h3f);
    cyc(1, 1, 1, 0, 6, 0, '0);
    chk(m_hold[6] == {m_en[6], m_sel[6]}, "R10 model", m_hold[6], {m_en[6], m_sel[6]});
    commit();
    check_outs("R10 copy back");

    // R11 write and commit on the same edge
    wr(9, 7'h48);
    cyc(1, 1, 0, 1, 9, 1, 7'h05);
    chk(sel_o[9*SW +: SW] == 6'h08 && en_o[9], "R11 old word", sel_o[9*SW +: SW], 8);
    commit();
    chk(sel_o[9*SW +: SW] == 6'h05 && !en_o[9], "R11 new word", sel_o[9*SW +: SW], 5);
    check_outs("R11 all");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule